// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic unit of a small microcoded 8-bit processor. It takes two 8-bit operands, a carry input and a 3-bit function code. It drives an 8-bit result combinationally. It also derives carry, signed-overflow and zero status from that result. The status bits are held in a condition-code register. That register captures them on a rising clock edge only when the microcode raises the flag-load strobe. The status bits cannot be written any other way.

There is no all-ones equality output. The zero bit is the NOR of all result bits, so any operation that leaves 00h sets it. A counter decremented to zero can feed a branch directly. Equality is tested by subtracting and reading zero. There are no opcodes for complement or left shift: XOR with FFh gives the complement, and adding an operand to itself gives a shift left by one.

Operands and function code are plain control-path inputs with no handshake. The result is valid in the same cycle. The flags are valid in the cycle after a load.

Top module: `alu8_core`

## Requirements
- R1: With func=3'b011 the result is (A + B + carry_in) mod 256. A flag load then sets carry to the unsigned carry-out of bit 7.
- R2: With func=3'b010 the result is A + ~B + carry_in. With carry_in=1 this is A-B. A flag load then sets carry to 1 when no borrow occurred.
- R3: With func=3'b001 the result is B + ~A + carry_in, which is B-A when carry_in=1. Carry follows the same no-borrow rule as R2.
- R4: func=3'b100 gives A XOR B, 3'b101 gives A OR B and 3'b110 gives A AND B. A flag load after any of these clears carry and overflow.
- R5: func=3'b000 gives 00h and func=3'b111 gives FFh, whatever the operands are. A flag load after either clears carry and overflow.
- R6: A flag load sets zero exactly when all 8 result bits are 0, for every function code.
- R7: After a flag load on codes 001, 010 or 011, overflow is 1 exactly when the signed result falls outside -128..+127. Overflow is the carry into bit 7 XOR the carry out of bit 7.
- R8: The flags change only at a rising clock edge with flag_load=1. With flag_load=0 they hold, even while the result changes.
- R9: Asserting rst_n low clears carry, overflow and zero at once. They stay cleared while rst_n is low, even if flag_load is high.
- R10: XOR with FFh returns the complement of A. A+A with carry_in=0 returns A shifted left by one, with the old bit 7 in carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| a_in | input | 8 | Operand A |
| b_in | input | 8 | Operand B |
| carry_in | input | 1 | Carry input to the adder |
| func | input | 3 | Function code (see R1-R5 encodings) |
| flag_load | input | 1 | Capture flags at the next rising edge |
| result | output | 8 | Combinational result |
| carry_o | output | 1 | Registered carry / no-borrow flag |
| ovf_o | output | 1 | Registered signed-overflow flag |
| zero_o | output | 1 | Registered zero flag |

## Verification
Two functions of this block can be active in the same cycle: the combinational result of a new operation, and the registered flags left from an earlier capture. The bench loads flags from a subtraction that yields zero. It then applies a different operation with flag_load low. In that cycle it checks that the result shows the new operation while carry, overflow and zero still hold the old values. A second case raises flag_load while reset is held and checks that reset wins.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
  typedef enum logic [2:0] {
    OP_CLR   = 3'd0,
    OP_BSUBA = 3'd1,
    OP_ASUBB = 3'd2,
    OP_ADD   = 3'd3,
    OP_XOR   = 3'd4,
    OP_OR    = 3'd5,
    OP_AND   = 3'd6,
    OP_SET   = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic v;
    logic z;
  } alu_flags_t;

  function automatic logic is_arith(alu_op_e op);
    return (op == OP_ADD) || (op == OP_ASUBB) || (op == OP_BSUBA);
  endfunction
endpackage

// File: rtl/alu8_operand_mux.sv
`timescale 1ns/1ps
module alu8_operand_mux
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e           op,
  input  logic [WIDTH-1:0]  a,
  input  logic [WIDTH-1:0]  b,
  output logic [WIDTH-1:0]  x,
  output logic [WIDTH-1:0]  y
);
  always_comb begin
    unique case (op)
      OP_ASUBB: begin x = a; y = ~b; end
      OP_BSUBA: begin x = b; y = ~a; end
      default:  begin x = a; y = b;  end
    endcase
  end
endmodule

// File: rtl/alu8_ripple_add.sv
`timescale 1ns/1ps
module alu8_ripple_add #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             c_out,
  output logic             c_msb_in
);
  logic [WIDTH:0] chain;
  assign chain[0] = cin;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_fa
      assign sum[i]     = x[i] ^ y[i] ^ chain[i];
      assign chain[i+1] = (x[i] & y[i]) | (chain[i] & (x[i] ^ y[i]));
    end
  endgenerate

  assign c_out    = chain[WIDTH];
  assign c_msb_in = chain[WIDTH-1];
endmodule

// File: rtl/alu8_logic_unit.sv
`timescale 1ns/1ps
module alu8_logic_unit
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    unique case (op)
      OP_XOR:  y = a ^ b;
      OP_OR:   y = a | b;
      OP_AND:  y = a & b;
      OP_SET:  y = '1;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu8_flag_reg.sv
`timescale 1ns/1ps
module alu8_flag_reg
  import alu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  alu_flags_t d,
  output alu_flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             carry_in,
  input  logic [2:0]       func,
  input  logic             flag_load,
  output logic [WIDTH-1:0] result,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             zero_o
);
  alu_op_e          op;
  logic [WIDTH-1:0] add_x, add_y, add_sum, lu_y;
  logic             add_c, add_c7;
  logic             arith;
  alu_flags_t       next_f, cur_f;

  assign op    = alu_op_e'(func);
  assign arith = is_arith(op);

  alu8_operand_mux #(.WIDTH(WIDTH)) u_mux (
    .op(op), .a(a_in), .b(b_in), .x(add_x), .y(add_y)
  );

  alu8_ripple_add #(.WIDTH(WIDTH)) u_add (
    .x(add_x), .y(add_y), .cin(carry_in),
    .sum(add_sum), .c_out(add_c), .c_msb_in(add_c7)
  );

  alu8_logic_unit #(.WIDTH(WIDTH)) u_lu (
    .op(op), .a(a_in), .b(b_in), .y(lu_y)
  );

  assign result = arith ? add_sum : lu_y;

  always_comb begin
    next_f.c = arith & add_c;
    next_f.v = arith & (add_c ^ add_c7);
    next_f.z = ~|result;
  end

  alu8_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .load(flag_load), .d(next_f), .q(cur_f)
  );

  assign carry_o = cur_f.c;
  assign ovf_o   = cur_f.v;
  assign zero_o  = cur_f.z;
endmodule

// File: rtl/alu8_core_chk.sv
`timescale 1ns/1ps
module alu8_core_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic             carry_in,
  input logic [2:0]       func,
  input logic             flag_load,
  input logic [WIDTH-1:0] result,
  input logic             carry_o,
  input logic             ovf_o,
  input logic             zero_o
);
  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_load |=> $stable({carry_o, ovf_o, zero_o}));

  // R6
  zero_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_load |=> (zero_o == ($past(result) == '0)));

  // R4
  logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_load && func[2] && func != 3'd7) |=> (!carry_o && !ovf_o));

  // R5
  clear_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (func == 3'd0) |-> (result == '0));

  // R7
  add_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_load && func == 3'd3) |=>
      (ovf_o == (($past(a_in[WIDTH-1]) == $past(b_in[WIDTH-1])) &&
                 ($past(result[WIDTH-1]) != $past(a_in[WIDTH-1])))));

  // R1
  add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_load && func == 3'd3) |=>
      (carry_o == $past(((WIDTH+1)'(a_in) + (WIDTH+1)'(b_in) + (WIDTH+1)'(carry_in)) >> WIDTH)));

  // R9
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert ({carry_o, ovf_o, zero_o} == 3'b000);
    end
  end
endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a_in = '0, b_in = '0;
  logic       carry_in = 1'b0;
  logic [2:0] func = '0;
  logic       flag_load = 1'b0;
  logic [7:0] result;
  logic       carry_o, ovf_o, zero_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core u_dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .carry_in(carry_in),
    .func(func), .flag_load(flag_load), .result(result),
    .carry_o(carry_o), .ovf_o(ovf_o), .zero_o(zero_o)
  );

  // {func, cin, a, b, expected result, c, v, z}
  localparam logic [30:0] VEC [NVEC] = '{
    {3'd3, 1'b0, 8'h01, 8'h01, 8'h02, 3'b000},
    {3'd3, 1'b0, 8'h7F, 8'h01, 8'h80, 3'b010},
    {3'd3, 1'b0, 8'hFF, 8'h01, 8'h00, 3'b101},
    {3'd3, 1'b1, 8'h80, 8'h80, 8'h01, 3'b110},
    {3'd3, 1'b0, 8'h01, 8'hFF, 8'h00, 3'b101},
    {3'd2, 1'b1, 8'h05, 8'h03, 8'h02, 3'b100},
    {3'd2, 1'b1, 8'h03, 8'h05, 8'hFE, 3'b000},
    {3'd2, 1'b1, 8'h80, 8'h01, 8'h7F, 3'b110},
    {3'd2, 1'b1, 8'h42, 8'h42, 8'h00, 3'b101},
    {3'd2, 1'b0, 8'h05, 8'h03, 8'h01, 3'b100},
    {3'd1, 1'b1, 8'h03, 8'h05, 8'h02, 3'b100},
    {3'd1, 1'b1, 8'h01, 8'h80, 8'h7F, 3'b110},
    {3'd4, 1'b1, 8'hA5, 8'hFF, 8'h5A, 3'b000},
    {3'd5, 1'b1, 8'h0F, 8'hF0, 8'hFF, 3'b000},
    {3'd6, 1'b1, 8'h0F, 8'hF0, 8'h00, 3'b001},
    {3'd0, 1'b1, 8'h12, 8'h34, 8'h00, 3'b001},
    {3'd7, 1'b1, 8'h00, 8'h00, 8'hFF, 3'b000},
    {3'd3, 1'b0, 8'hC3, 8'hC3, 8'h86, 3'b100}
  };

  function automatic string op_tag(logic [2:0] f);
    case (f)
      3'd3: return "R1";
      3'd2: return "R2";
      3'd1: return "R3";
      3'd0, 3'd7: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic apply(logic [2:0] f, logic ci, logic [7:0] a, logic [7:0] b, logic ld);
    func = f; carry_in = ci; a_in = a; b_in = b; flag_load = ld;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9", {5'd0, carry_o, ovf_o, zero_o}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      apply(VEC[i][30:28], VEC[i][27], VEC[i][26:19], VEC[i][18:11], 1'b1);
      #1;
      chk(op_tag(VEC[i][30:28]), result, VEC[i][10:3]);
      @(negedge clk);
      chk(VEC[i][30:28] >= 3'd4 || VEC[i][30:28] == 3'd0 ? "R4/R5 carry" : op_tag(VEC[i][30:28]),
          {7'd0, carry_o}, {7'd0, VEC[i][2]});
      chk("R7", {7'd0, ovf_o}, {7'd0, VEC[i][1]});
      chk("R6", {7'd0, zero_o}, {7'd0, VEC[i][0]});
      flag_load = 1'b0;
    end

    // R10 complement via XOR with FFh
    @(negedge clk);
    apply(3'd4, 1'b0, 8'h3C, 8'hFF, 1'b0);
    #1 chk("R10", result, 8'hC3);
    // R10 shift left via A+A, old bit 7 into carry
    @(negedge clk);
    apply(3'd3, 1'b0, 8'hB1, 8'hB1, 1'b1);
    #1 chk("R10", result, 8'h62);
    @(negedge clk);
    flag_load = 1'b0;
    chk("R10", {7'd0, carry_o}, 8'h01);

    // R8: capture zero from equality subtract, then new op with load low
    apply(3'd2, 1'b1, 8'h77, 8'h77, 1'b1);
    @(negedge clk);
    apply(3'd3, 1'b0, 8'h7F, 8'h7F, 1'b0);
    #1 chk("R8 result", result, 8'hFE);
    @(negedge clk);
    chk("R8", {5'd0, carry_o, ovf_o, zero_o}, 8'h05);
    @(negedge clk);
    chk("R8", {5'd0, carry_o, ovf_o, zero_o}, 8'h05);

    // R5 operands ignored by preset
    apply(3'd7, 1'b0, 8'h5A, 8'hA5, 1'b0);
    #1 chk("R5", result, 8'hFF);

    // R9 reset with load held high
    @(negedge clk);
    apply(3'd3, 1'b0, 8'hFF, 8'h01, 1'b1);
    #1 rst_n = 1'b0;
    #1 chk("R9", {5'd0, carry_o, ovf_o, zero_o}, 8'h00);
    @(negedge clk);
    chk("R9", {5'd0, carry_o, ovf_o, zero_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 release", {5'd0, carry_o, ovf_o, zero_o}, 8'h05);
    flag_load = 1'b0;

    @(negedge clk);
    finish_run();
  end
endmodule